// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Scan Controller

This block drives a four-character display built from 5x7 LED cells. The cells share seven row lines, and each cell has five column lines of its own, which gives twenty column outputs. The block turns the seven rows on one at a time. Each row stays active for a fixed slot of clock cycles. A full pass over all seven rows is one frame.

At the start of each slot the block reads the five-bit slice of every character for the row that is active. It gets these slices one character per clock from an external glyph table, and the table answers one clock after it is asked. The slices are held for the rest of the slot and drive the columns.

Two more inputs change what is shown. A per-character marker, together with a global marker-enable level, replaces that character with a solid block of dots at half duty. An active-low blank input turns every drive off at once. The blank input can be toggled fast to dim the display, and it does not change any stored state.

Top module: `dot_scan_ctrl`

## Requirements
- R1: While reset is held and just after it is released: `col_o` is all zero, `row_o` is `7'b0000001` (row 0 active, when `blank_ni` is high), `font_row_o` is 0, and `font_code_o` is the code of character 0.
- R2: With `blank_ni` high, exactly one bit of `row_o` is set. The active row index starts at 0, moves up by one every 128 clocks, and goes back to 0 after row 6.
- R3: In clock k of a slot, for k from 0 to 3, `font_code_o` carries `code_i[7k+6:7k]` and `font_row_o` carries the index of the active row. The glyph bits for that request must arrive on `font_bits_i` during clock k+1.
- R4: In clocks 5 to 127 of a slot, for a character with no marker shown, `col_o[5d+b]` equals bit b of the glyph slice returned for character d in that slot.
- R5: In clocks 0 to 4 of every slot, all of `col_o` is zero. This gap keeps one row's data from ghosting into the next row.
- R6: Take character d with `cursor_i[d]` and `cursor_en_i` both high when its slice is latched (the end of clock d+1). For that slot, `col_o[5d+4:5d]` is `5'h1f` in clocks 5 to 63 and zero in clocks 64 to 127.
- R7: If `cursor_en_i` is low, or `cursor_i[d]` is low, the stored character d is shown normally, starting from the next slot that latches it. The marker state itself is never changed by `cursor_en_i`.
- R8: While `blank_ni` is low, `row_o` and `col_o` are all zero in that same cycle, with no clock delay. When `blank_ni` goes high again, the normal output returns in the same cycle, with nothing lost.
- R9: A change on `code_i` shows up in the columns of every row within one frame. It first appears in the first slot whose fetch clock for that character comes after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 28 | Four 7-bit character codes; character d is at bits 7d+6:7d |
| cursor_i | input | 4 | Marker bit for each character |
| cursor_en_i | input | 1 | Global marker enable |
| blank_ni | input | 1 | Active-low blank; forces all drives off at once |
| font_code_o | output | 7 | Code sent to the glyph table |
| font_row_o | output | 3 | Row index sent to the glyph table |
| font_bits_i | input | 5 | Glyph slice, valid one clock after the request |
| row_o | output | 7 | One-hot row drive |
| col_o | output | 20 | Column drive; character d uses bits 5d+4:5d |

## Verification
Blanking is combinational, and it can meet both the interdigit gap and the edge where a marker switches to half duty. The bench toggles `blank_ni` in irregular periods of 37 and 23 clocks. This makes blank edges fall on clocks 0 to 4 of a slot and on clock 63/64 while markers are shown. Marker-enable changes are also placed between the fetch clocks of different characters. A behavioural model predicts `row_o` and `col_o` on every clock and checks that blank wins over every other condition in the same cycle.

// File: rtl/dot_scan_pkg.sv
package dot_scan_pkg;
  // position of the scan inside one row slot
  typedef enum logic [1:0] {
    PH_DARK   = 2'd0,  // fetch + interdigit gap
    PH_BRIGHT = 2'd1,  // full-duty window
    PH_DIM    = 2'd2   // second half, marker dots off
  } slot_phase_e;
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import dot_scan_pkg::*;
#(
  parameter int SLOT_CLKS = 128,
  parameter int ROWS      = 7,
  parameter int GAP       = 5,
  parameter int HALF      = 64,
  localparam int CNT_W    = $clog2(SLOT_CLKS),
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] slot_cnt_o,
  output logic [ROW_W-1:0] row_idx_o,
  output slot_phase_e      phase_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      row_q <= '0;
    end else if (cnt_q == CNT_W'(SLOT_CLKS - 1)) begin
      cnt_q <= '0;
      row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q < CNT_W'(GAP))       phase_o = PH_DARK;
    else if (cnt_q < CNT_W'(HALF)) phase_o = PH_BRIGHT;
    else                           phase_o = PH_DIM;
  end

  assign slot_cnt_o = cnt_q;
  assign row_idx_o  = row_q;

endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch #(
  parameter int NUM_DIGITS = 4,
  parameter int CODE_W     = 7,
  parameter int GLYPH_W    = 5,
  parameter int CNT_W      = 7,
  parameter int ROW_W      = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CNT_W-1:0]              slot_cnt_i,
  input  logic [ROW_W-1:0]              row_idx_i,
  input  logic [NUM_DIGITS*CODE_W-1:0]  code_i,
  input  logic [NUM_DIGITS-1:0]         cursor_i,
  input  logic                          cursor_en_i,
  input  logic [GLYPH_W-1:0]            font_bits_i,
  output logic [CODE_W-1:0]             font_code_o,
  output logic [ROW_W-1:0]              font_row_o,
  output logic [NUM_DIGITS*GLYPH_W-1:0] glyph_o,
  output logic [NUM_DIGITS-1:0]         mark_o
);

  // request digit k in slot clock k; table answers in clock k+1
  always_comb begin
    font_code_o = code_i[CODE_W-1:0];
    for (int d = 1; d < NUM_DIGITS; d++) begin
      if (slot_cnt_i == CNT_W'(d)) font_code_o = code_i[d*CODE_W +: CODE_W];
    end
  end

  assign font_row_o = row_idx_i;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    logic [GLYPH_W-1:0] glyph_q;
    logic               mark_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        glyph_q <= '0;
        mark_q  <= 1'b0;
      end else if (slot_cnt_i == CNT_W'(d + 1)) begin
        glyph_q <= font_bits_i;
        mark_q  <= cursor_en_i & cursor_i[d];
      end
    end

    assign glyph_o[d*GLYPH_W +: GLYPH_W] = glyph_q;
    assign mark_o[d]                     = mark_q;
  end

endmodule

// File: rtl/col_drive.sv
module col_drive
  import dot_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int GLYPH_W    = 5,
  parameter int ROWS       = 7,
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  slot_phase_e                   phase_i,
  input  logic [ROW_W-1:0]              row_idx_i,
  input  logic [NUM_DIGITS*GLYPH_W-1:0] glyph_i,
  input  logic [NUM_DIGITS-1:0]         mark_i,
  input  logic                          blank_ni,
  output logic [ROWS-1:0]               row_o,
  output logic [NUM_DIGITS*GLYPH_W-1:0] col_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_o[r] = blank_ni && (row_idx_i == ROW_W'(r));
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_col
    logic [GLYPH_W-1:0] lit;
    always_comb begin
      if (!blank_ni || phase_i == PH_DARK) lit = '0;
      else if (mark_i[d])                  lit = (phase_i == PH_BRIGHT) ? '1 : '0;
      else                                 lit = glyph_i[d*GLYPH_W +: GLYPH_W];
    end
    assign col_o[d*GLYPH_W +: GLYPH_W] = lit;
  end

endmodule

// File: rtl/dot_scan_ctrl.sv
module dot_scan_ctrl
  import dot_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int CODE_W     = 7,
  parameter int GLYPH_W    = 5,
  parameter int ROWS       = 7,
  parameter int SLOT_CLKS  = 128,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int CNT_W     = $clog2(SLOT_CLKS),
  localparam int COLS      = NUM_DIGITS * GLYPH_W,
  localparam int GAP       = NUM_DIGITS + 1,
  localparam int HALF      = SLOT_CLKS / 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_DIGITS*CODE_W-1:0] code_i,
  input  logic [NUM_DIGITS-1:0]        cursor_i,
  input  logic                         cursor_en_i,
  input  logic                         blank_ni,
  output logic [CODE_W-1:0]            font_code_o,
  output logic [ROW_W-1:0]             font_row_o,
  input  logic [GLYPH_W-1:0]           font_bits_i,
  output logic [ROWS-1:0]              row_o,
  output logic [COLS-1:0]              col_o
);

  logic [CNT_W-1:0] slot_cnt;
  logic [ROW_W-1:0] row_idx;
  slot_phase_e      phase;
  logic [COLS-1:0]  glyph;
  logic [NUM_DIGITS-1:0] mark;

  scan_timer #(
    .SLOT_CLKS(SLOT_CLKS), .ROWS(ROWS), .GAP(GAP), .HALF(HALF)
  ) i_timer (
    .clk_i, .rst_ni,
    .slot_cnt_o(slot_cnt), .row_idx_o(row_idx), .phase_o(phase)
  );

  glyph_fetch #(
    .NUM_DIGITS(NUM_DIGITS), .CODE_W(CODE_W), .GLYPH_W(GLYPH_W),
    .CNT_W(CNT_W), .ROW_W(ROW_W)
  ) i_fetch (
    .clk_i, .rst_ni,
    .slot_cnt_i(slot_cnt), .row_idx_i(row_idx),
    .code_i, .cursor_i, .cursor_en_i, .font_bits_i,
    .font_code_o, .font_row_o,
    .glyph_o(glyph), .mark_o(mark)
  );

  col_drive #(
    .NUM_DIGITS(NUM_DIGITS), .GLYPH_W(GLYPH_W), .ROWS(ROWS)
  ) i_drive (
    .phase_i(phase), .row_idx_i(row_idx),
    .glyph_i(glyph), .mark_i(mark), .blank_ni,
    .row_o, .col_o
  );

endmodule

// File: rtl/dot_scan_chk.sv
module dot_scan_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int ROWS       = 7,
  parameter int COLS       = 20,
  parameter int SLOT_CLKS  = 128,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int CNT_W     = $clog2(SLOT_CLKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_ni,
  input logic [ROW_W-1:0] font_row_o,
  input logic [ROWS-1:0]  row_o,
  input logic [COLS-1:0]  col_o
);

  // independent slot position
  logic [CNT_W-1:0] pos_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= (pos_q == CNT_W'(SLOT_CLKS - 1)) ? '0 : pos_q + 1'b1;
  end

  assert_row_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_ni |-> $countones(row_o) == 1);

  assert_row_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && $past(blank_ni) && pos_q != '0) |-> row_o == $past(row_o));

  assert_font_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && pos_q < CNT_W'(NUM_DIGITS)) |-> row_o[font_row_o]);

  assert_gap_dark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q <= CNT_W'(NUM_DIGITS)) |-> col_o == '0);

  assert_blank_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (row_o == '0 && col_o == '0));

endmodule

bind dot_scan_ctrl dot_scan_chk #(
  .NUM_DIGITS(NUM_DIGITS), .ROWS(ROWS), .COLS(COLS), .SLOT_CLKS(SLOT_CLKS)
) i_dot_scan_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .blank_ni(blank_ni),
  .font_row_o(font_row_o), .row_o(row_o), .col_o(col_o)
);

// File: tb/test_dot_scan_ctrl.sv
module test_dot_scan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] code = '0;
  logic [3:0]  curs = '0;
  logic        curs_en = 1'b0;
  logic        blank_n = 1'b1;
  logic [6:0]  font_code;
  logic [2:0]  font_row;
  logic [4:0]  font_q = '0;
  logic [6:0]  row;
  logic [19:0] col;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dot_scan_ctrl i_dot_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .cursor_i(curs),
    .cursor_en_i(curs_en), .blank_ni(blank_n),
    .font_code_o(font_code), .font_row_o(font_row), .font_bits_i(font_q),
    .row_o(row), .col_o(col)
  );

  function automatic logic [4:0] glyph_of(logic [6:0] c, int r);
    return 5'((int'(c) * 3 + r * 7 + (int'(c) >> 4)) & 31);
  endfunction

  // glyph table: one clock latency
  always @(posedge clk) font_q <= glyph_of(font_code, int'(font_row));

  // behavioural reference model
  int        mcnt = 0, mrow = 0;
  logic [6:0] msnap [4];
  logic [4:0] mbuf [4];
  bit         mcur [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; mrow = 0;
      for (int d = 0; d < 4; d++) begin mbuf[d] = '0; mcur[d] = 0; msnap[d] = '0; end
    end else begin
      if (mcnt >= 1 && mcnt <= 4) begin
        mbuf[mcnt-1] = glyph_of(msnap[mcnt-1], mrow);
        mcur[mcnt-1] = curs_en && curs[mcnt-1];
      end
      if (mcnt < 4) msnap[mcnt] = code[mcnt*7 +: 7];
      mcnt++;
      if (mcnt == 128) begin mcnt = 0; mrow = (mrow + 1) % 7; end
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cnt=%0d row=%0d: got %h expected %h", req, mcnt, mrow, got, exp);
    end
  endtask

  task automatic compare();
    logic [19:0] ecol;
    string tag;
    ecol = '0;
    tag = "R4";
    if (!blank_n) tag = "R8";
    else if (mcnt < 5) tag = "R5";
    for (int d = 0; d < 4; d++) begin
      if (blank_n && mcnt >= 5) begin
        if (mcur[d]) begin
          ecol[d*5 +: 5] = (mcnt < 64) ? 5'h1f : 5'h00;
          if (tag == "R4") tag = "R6";
        end else begin
          ecol[d*5 +: 5] = mbuf[d];
          if (curs[d] && !curs_en && tag == "R4") tag = "R7";
        end
      end
    end
    check(tag, 32'(col), 32'(ecol));
    check(blank_n ? "R2" : "R8", 32'(row), blank_n ? 32'(1 << mrow) : 32'd0);
    if (mcnt < 4) begin
      check("R3", 32'(font_code), 32'(code[mcnt*7 +: 7]));
      check("R3", 32'(font_row), 32'(mrow));
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      compare();
    end
  endtask

  task automatic blink(int n, int period);
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (i % period == period - 1) blank_n = ~blank_n;
    end
    blank_n = 1'b1;
  endtask

  initial begin
    code = {7'h41, 7'h2c, 7'h7f, 7'h15};
    #23;
    // R1: state under reset and right after release
    check("R1", 32'(col), 32'd0);
    check("R1", 32'(row), 32'd1);
    check("R1", 32'(font_row), 32'd0);
    check("R1", 32'(font_code), 32'h15);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 32'(col), 32'd0);
    check("R1", 32'(font_code), 32'h15);

    tick(7 * 128 + 40);                 // R2/R4: full frame of glyphs
    code[14 +: 7] = 7'h33;              // R9: rewrite mid-slot
    tick(128);
    // R9: next slot shows the new code for character 2
    while (mcnt != 10) tick(1);
    check("R9", 32'(col[10 +: 5]), 32'(glyph_of(7'h33, mrow)));
    tick(7 * 128);

    curs = 4'b1010; curs_en = 1'b1;     // R6
    tick(2 * 128);
    while (mcnt != 3) tick(1);
    curs_en = 1'b0;                     // between fetches of digit 1 and 3
    tick(128 + 20);
    check("R7", 32'(col[5 +: 5]), 32'(glyph_of(code[7 +: 7], mrow)));
    curs_en = 1'b1;
    tick(256);

    blink(7 * 128, 37);                 // R8 against gap and half-duty edge
    curs = 4'b0101;
    blink(7 * 128, 23);
    for (int k = 0; k < 6; k++) begin   // R9: rewrite all codes, flash marker
      code = {7'(k * 19 + 5), 7'(k * 7), 7'(k * 31 + 2), 7'(k * 11 + 64)};
      curs_en = k[0];
      tick(7 * 128 + 13);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule